// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Port

This block is the host-facing register front end of a real-time clock. A host reaches a 128-byte register space through two byte-wide addresses. A write to the even address selects a register. Accesses to the odd address then read or write the selected byte. Four of the indexes are control registers owned by this block: a rate/divider register (index 0x0A), a mode and enable register (0x0B), a status register (0x0C) and a validity register (0x0D). Every other index is a plain byte array. Time counting happens elsewhere. Its periodic, alarm and update events reach this block as single-cycle set pulses.

The block keeps a phase counter that advances on a base tick (nominally 32768 Hz) whenever the clock is running. A four-state machine follows that phase. TS_HOLD is entered whenever divider bits 6:5 read 11, from any state. TS_STOP is entered when the clock is not running and not held. TS_COUNT covers the running part of each second outside the final window. TS_WINDOW covers the final UIP_TICKS ticks of each second.

The transitions are as follows. Any state moves to TS_HOLD when the hold code appears. TS_HOLD leaves to TS_COUNT, TS_WINDOW or TS_STOP when the code is released. TS_COUNT moves to TS_WINDOW when the phase enters the window. TS_WINDOW returns to TS_COUNT when the phase wraps to zero. TS_COUNT and TS_WINDOW fall to TS_STOP when running stops, and TS_STOP resumes into TS_COUNT or TS_WINDOW depending on the phase. The update-in-progress bit seen in bit 7 of the rate register is derived from TS_WINDOW and is never stored. The interrupt line is the request bit of the status register, so it is level-sensitive.

Top module: `rtc_regif`

## Requirements
- R1: A write to the even address loads the index from data bits 6:0; bit 7 is dropped. A read of the even address returns 0xFF.
- R2: Odd-address accesses to any index other than 0x0A–0x0D write and read back a plain byte at that index.
- R3: After hardware reset, the registers read as follows: rate register 0x26, mode register 0x02, status register 0x00, validity register 0x80. The interrupt line is low.
- R4: An odd-address read of the status register returns its current value and clears the whole register at that clock edge, which lowers the interrupt line. An event pulse arriving on the same edge still sets its flag afterwards.
- R5: Writes to the status and validity registers have no effect. Bit 7 of the rate register ignores written values and always shows the generated update-in-progress state.
- R6: An event pulse sets its flag in the status register: periodic sets bit 6, alarm sets bit 5, update sets bit 4. If the matching enable bit in the mode register (6, 5 or 4 respectively) is set, bit 7 (request) is also set. The interrupt output follows bit 7.
- R7: A write to the mode register with bit 7 (SET) at 1 stores bit 4 as 0 regardless of the data. The update-in-progress bit then reads 0.
- R8: On a write to the mode register, the request bit is set if any written enable bit among 6:4 matches a pending flag in status bits 6:4. Otherwise the request bit is cleared.
- R9: A functional reset pulse clears mode bits 6, 5 and 3 and the whole status register, and lowers the interrupt line. The other mode bits are kept.
- R10: While running, update-in-progress reads 1 exactly while the phase lies in the last UIP_TICKS base ticks of each second of TICKS_PER_SEC ticks. Otherwise it reads 0.
- R11: The clock runs (clk_run high, phase advancing on each base tick) only when mode bit 7 is 0 and rate bits 6:4 are 010 or lower. Otherwise the phase is frozen.
- R12: Rate bits 6:5 at 11 hold the divider with the phase parked at half a second. After release, the first update window opens TICKS_PER_SEC/2 − UIP_TICKS ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low hardware reset |
| func_rst | input | 1 | Functional reset pulse for enables and flags |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | 1 | 0 selects the index, 1 selects data |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the current address and index |
| base_tick | input | 1 | One-cycle pulse per base-clock period |
| ev_periodic | input | 1 | Periodic event set pulse |
| ev_alarm | input | 1 | Alarm event set pulse |
| ev_update | input | 1 | Update-ended event set pulse |
| irq_o | output | 1 | Level interrupt request |
| clk_run | output | 1 | High while the time keeper may count |

## Verification
The properties assume that host_wr and host_rd are never high in the same cycle. They also assume that event pulses and the functional reset come from synchronous logic on the same clock. The interrupt-raise property further excludes cycles in which the host writes data, because a concurrent mode-register write may legally withdraw an enable. The bench drives every strobe for exactly one clock, changes inputs only on the falling edge, and never overlaps a write with a read. It overlaps an event with a status read only in the one scenario that targets that ordering.

// File: rtl/rtc_regif_pkg.sv
`timescale 1ns/1ps
package rtc_regif_pkg;
    // control register indexes
    localparam int unsigned IDX_RATE   = 10;
    localparam int unsigned IDX_MODE   = 11;
    localparam int unsigned IDX_STAT   = 12;
    localparam int unsigned IDX_VALID  = 13;

    // mode register bits
    localparam int unsigned M_SET  = 7;
    localparam int unsigned M_UIE  = 4;   // update enable, alarm = +1, periodic = +2
    localparam int unsigned M_AIE  = 5;
    localparam int unsigned M_PIE  = 6;
    localparam int unsigned M_SQW  = 3;

    // status register bits
    localparam int unsigned S_REQ  = 7;
    localparam int unsigned S_UF   = 4;   // alarm = +1, periodic = +2

    localparam int unsigned N_SRC  = 3;

    localparam logic [6:0] RATE_RST  = 7'h26;
    localparam logic [7:0] MODE_RST  = 8'h02;
    localparam logic [7:0] VALID_VAL = 8'h80;

    typedef enum logic [1:0] {
        TS_HOLD   = 2'd0,
        TS_STOP   = 2'd1,
        TS_COUNT  = 2'd2,
        TS_WINDOW = 2'd3
    } tmr_state_e;
endpackage

// File: rtl/rtc_host_port.sv
`timescale 1ns/1ps
module rtc_host_port #(
    parameter int unsigned IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic             host_addr,
    input  logic [IDX_W-1:0] idx_data,
    output logic [IDX_W-1:0] idx_q,
    output logic             dat_wr,
    output logic             dat_rd
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (host_wr && !host_addr) begin
            idx_q <= idx_data;
        end
    end

    assign dat_wr = host_wr && host_addr;
    assign dat_rd = host_rd && host_addr;
endmodule

// File: rtl/rtc_byte_store.sv
`timescale 1ns/1ps
module rtc_byte_store #(
    parameter int unsigned IDX_W = 7,
    parameter int unsigned DW    = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/rtc_uip_timer.sv
`timescale 1ns/1ps
module rtc_uip_timer
    import rtc_regif_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 32768,
    parameter int unsigned UIP_TICKS     = 8,
    localparam int unsigned PH_W         = $clog2(TICKS_PER_SEC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            base_tick,
    input  logic [2:0]      div_sel,
    input  logic            set_mode,
    output logic            run,
    output logic            hold,
    output logic            uip,
    output logic [PH_W-1:0] phase
);
    localparam int unsigned LAST      = TICKS_PER_SEC - 1;
    localparam int unsigned WIN_START = TICKS_PER_SEC - UIP_TICKS;
    localparam int unsigned HALF      = TICKS_PER_SEC / 2;

    tmr_state_e      st_q, st_n;
    logic [PH_W-1:0] phase_n;
    logic            in_win_n;

    assign run  = !set_mode && (div_sel <= 3'b010);
    assign hold = (div_sel[2:1] == 2'b11);

    always_comb begin
        phase_n = phase;
        if (hold) begin
            phase_n = PH_W'(HALF);
        end else if (run && base_tick) begin
            phase_n = (phase == PH_W'(LAST)) ? '0 : phase + 1'b1;
        end
    end

    assign in_win_n = (phase_n >= PH_W'(WIN_START));

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            TS_HOLD: begin
                if (!hold) begin
                    st_n = !run ? TS_STOP : (in_win_n ? TS_WINDOW : TS_COUNT);
                end
            end
            TS_STOP: begin
                if (hold) begin
                    st_n = TS_HOLD;
                end else if (run) begin
                    st_n = in_win_n ? TS_WINDOW : TS_COUNT;
                end
            end
            TS_COUNT: begin
                if (hold) begin
                    st_n = TS_HOLD;
                end else if (!run) begin
                    st_n = TS_STOP;
                end else if (in_win_n) begin
                    st_n = TS_WINDOW;
                end
            end
            TS_WINDOW: begin
                if (hold) begin
                    st_n = TS_HOLD;
                end else if (!run) begin
                    st_n = TS_STOP;
                end else if (!in_win_n) begin
                    st_n = TS_COUNT;
                end
            end
            default: st_n = TS_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TS_COUNT;
            phase <= '0;
        end else begin
            st_q  <= st_n;
            phase <= phase_n;
        end
    end

    // output process: window state, gated by the present run condition
    always_comb begin
        uip = 1'b0;
        unique case (st_q)
            TS_WINDOW: uip = run;
            default:   uip = 1'b0;
        endcase
    end
endmodule

// File: rtl/rtc_ctrl_regs.sv
`timescale 1ns/1ps
module rtc_ctrl_regs
    import rtc_regif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             func_rst,
    input  logic             wr_rate,
    input  logic             wr_mode,
    input  logic             rd_stat,
    input  logic [7:0]       wdata,
    input  logic [N_SRC-1:0] ev,
    output logic [6:0]       rate_q,
    output logic [7:0]       mode_q,
    output logic [7:0]       stat_q
);
    logic [6:0] rate_n;
    logic [7:0] mode_n, stat_n, mode_w;

    always_comb begin
        rate_n = rate_q;
        mode_n = mode_q;
        stat_n = stat_q;
        mode_w = wdata;

        if (wr_rate) begin
            rate_n = wdata[6:0];
        end

        if (wr_mode) begin
            if (mode_w[M_SET]) begin
                mode_w[M_UIE] = 1'b0;
            end
            mode_n = mode_w;
            stat_n[S_REQ] = |(mode_w[M_UIE +: N_SRC] & stat_q[S_UF +: N_SRC]);
        end

        if (rd_stat) begin
            stat_n = '0;
        end

        for (int k = 0; k < N_SRC; k++) begin
            if (ev[k]) begin
                stat_n[S_UF + k] = 1'b1;
                if (mode_n[M_UIE + k]) begin
                    stat_n[S_REQ] = 1'b1;
                end
            end
        end

        if (func_rst) begin
            mode_n[M_PIE] = 1'b0;
            mode_n[M_AIE] = 1'b0;
            mode_n[M_SQW] = 1'b0;
            stat_n        = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q <= RATE_RST;
            mode_q <= MODE_RST;
            stat_q <= '0;
        end else begin
            rate_q <= rate_n;
            mode_q <= mode_n;
            stat_q <= stat_n;
        end
    end
endmodule

// File: rtl/rtc_regif.sv
`timescale 1ns/1ps
module rtc_regif
    import rtc_regif_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 32768,
    parameter int unsigned UIP_TICKS     = 8,
    parameter int unsigned IDX_W         = 7,
    localparam int unsigned PH_W         = $clog2(TICKS_PER_SEC)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       func_rst,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       base_tick,
    input  logic       ev_periodic,
    input  logic       ev_alarm,
    input  logic       ev_update,
    output logic       irq_o,
    output logic       clk_run
);
    logic [IDX_W-1:0] idx_w;
    logic             dat_wr, dat_rd;
    logic             hit_rate, hit_mode, hit_stat, hit_valid, hit_ctrl;
    logic [6:0]       rate_w;
    logic [7:0]       reg_b_w, stat_w, store_rd;
    logic [N_SRC-1:0] ev_w;
    logic             run_w, hold_w, uip_w;
    logic [PH_W-1:0]  phase_w;

    assign ev_w = {ev_periodic, ev_alarm, ev_update};

    rtc_host_port #(.IDX_W(IDX_W)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_wr  (host_wr),
        .host_rd  (host_rd),
        .host_addr(host_addr),
        .idx_data (host_wdata[IDX_W-1:0]),
        .idx_q    (idx_w),
        .dat_wr   (dat_wr),
        .dat_rd   (dat_rd)
    );

    assign hit_rate  = (idx_w == IDX_W'(IDX_RATE));
    assign hit_mode  = (idx_w == IDX_W'(IDX_MODE));
    assign hit_stat  = (idx_w == IDX_W'(IDX_STAT));
    assign hit_valid = (idx_w == IDX_W'(IDX_VALID));
    assign hit_ctrl  = hit_rate || hit_mode || hit_stat || hit_valid;

    rtc_ctrl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .func_rst(func_rst),
        .wr_rate (dat_wr && hit_rate),
        .wr_mode (dat_wr && hit_mode),
        .rd_stat (dat_rd && hit_stat),
        .wdata   (host_wdata),
        .ev      (ev_w),
        .rate_q  (rate_w),
        .mode_q  (reg_b_w),
        .stat_q  (stat_w)
    );

    rtc_uip_timer #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .UIP_TICKS    (UIP_TICKS)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_tick(base_tick),
        .div_sel  (rate_w[6:4]),
        .set_mode (reg_b_w[M_SET]),
        .run      (run_w),
        .hold     (hold_w),
        .uip      (uip_w),
        .phase    (phase_w)
    );

    rtc_byte_store #(.IDX_W(IDX_W), .DW(8)) u_store (
        .clk  (clk),
        .we   (dat_wr && !hit_ctrl),
        .addr (idx_w),
        .wdata(host_wdata),
        .rdata(store_rd)
    );

    always_comb begin
        if (!host_addr) begin
            host_rdata = 8'hFF;
        end else if (hit_rate) begin
            host_rdata = {uip_w, rate_w};
        end else if (hit_mode) begin
            host_rdata = reg_b_w;
        end else if (hit_stat) begin
            host_rdata = stat_w;
        end else if (hit_valid) begin
            host_rdata = VALID_VAL;
        end else begin
            host_rdata = store_rd;
        end
    end

    assign irq_o   = stat_w[S_REQ];
    assign clk_run = run_w;
endmodule

// File: rtl/rtc_regif_chk.sv
`timescale 1ns/1ps
module rtc_regif_chk #(
    parameter int unsigned TICKS_PER_SEC = 32768,
    parameter int unsigned UIP_TICKS     = 8,
    parameter int unsigned IDX_W         = 7,
    localparam int unsigned PH_W         = $clog2(TICKS_PER_SEC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             func_rst,
    input logic             host_wr,
    input logic             host_rd,
    input logic             host_addr,
    input logic [IDX_W-1:0] idx_w,
    input logic [2:0]       ev_w,
    input logic [7:0]       reg_b_w,
    input logic             irq_o,
    input logic             uip_w,
    input logic             run_w,
    input logic             hold_w,
    input logic [PH_W-1:0]  phase_w
);
    localparam int unsigned WIN_START = TICKS_PER_SEC - UIP_TICKS;
    localparam int unsigned HALF      = TICKS_PER_SEC / 2;

    a_r7_set_no_uie: assert property (@(posedge clk) disable iff (!rst_n)
        reg_b_w[7] |-> !reg_b_w[4]);

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr && idx_w == IDX_W'(12) && ev_w == 3'b000 && !host_wr)
        |=> !irq_o);

    a_r6_event_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(ev_w & reg_b_w[6:4])) && !func_rst && !(host_wr && host_addr))
        |=> irq_o);

    a_r9_func_rst: assert property (@(posedge clk) disable iff (!rst_n)
        func_rst |=> (!irq_o && reg_b_w[6:5] == 2'b00 && !reg_b_w[3]));

    a_r10_uip_window: assert property (@(posedge clk) disable iff (!rst_n)
        uip_w |-> (phase_w >= PH_W'(WIN_START)));

    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && !hold_w) |=> $stable(phase_w));

    a_r12_hold_half: assert property (@(posedge clk) disable iff (!rst_n)
        hold_w |=> (phase_w == PH_W'(HALF)));
endmodule

bind rtc_regif rtc_regif_chk #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .UIP_TICKS    (UIP_TICKS),
    .IDX_W        (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .func_rst (func_rst),
    .host_wr  (host_wr),
    .host_rd  (host_rd),
    .host_addr(host_addr),
    .idx_w    (idx_w),
    .ev_w     (ev_w),
    .reg_b_w  (reg_b_w),
    .irq_o    (irq_o),
    .uip_w    (uip_w),
    .run_w    (run_w),
    .hold_w   (hold_w),
    .phase_w  (phase_w)
);

// File: tb/sim_rtc_regif.sv
`timescale 1ns/1ps
module sim_rtc_regif;
    localparam int unsigned TPS = 64;
    localparam int unsigned UIT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       func_rst = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0, host_addr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       base_tick = 1'b0;
    logic       ev_periodic = 1'b0, ev_alarm = 1'b0, ev_update = 1'b0;
    logic       irq_o, clk_run;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rtc_regif #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIT)) u0 (
        .clk(clk), .rst_n(rst_n), .func_rst(func_rst),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .base_tick(base_tick),
        .ev_periodic(ev_periodic), .ev_alarm(ev_alarm), .ev_update(ev_update),
        .irq_o(irq_o), .clk_run(clk_run)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        host_wr = 0; host_rd = 0; host_addr = 0; base_tick = 0;
        ev_periodic = 0; ev_alarm = 0; ev_update = 0; func_rst = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] i, input logic [7:0] d);
        bus_write(1'b0, i);
        bus_write(1'b1, d);
    endtask

    task automatic reg_read(input logic [7:0] i, output logic [7:0] d);
        bus_write(1'b0, i);
        bus_read(1'b1, d);
    endtask

    task automatic give_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); base_tick = 1'b1;
            @(negedge clk); base_tick = 1'b0;
        end
    endtask

    task automatic pulse_ev(input int which);
        @(negedge clk);
        ev_update = (which == 0); ev_alarm = (which == 1); ev_periodic = (which == 2);
        @(negedge clk);
        ev_update = 0; ev_alarm = 0; ev_periodic = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        check("R3 irq after reset", {7'd0, irq_o}, 8'h00);
        check("R11 running after reset", {7'd0, clk_run}, 8'h01);
        reg_read(8'h0A, v); check("R3 rate reset", v, 8'h26);
        reg_read(8'h0B, v); check("R3 mode reset", v, 8'h02);
        reg_read(8'h0C, v); check("R3 status reset", v, 8'h00);
        reg_read(8'h0D, v); check("R3 valid reset", v, 8'h80);
    endtask

    task automatic t_index();
        logic [7:0] v;
        do_reset();
        bus_write(1'b0, 8'h8B);
        bus_read(1'b1, v); check("R1 index bit7 dropped", v, 8'h02);
        bus_read(1'b0, v); check("R1 even read", v, 8'hFF);
    endtask

    task automatic t_store();
        logic [7:0] v;
        do_reset();
        reg_write(8'h20, 8'h5A);
        reg_write(8'h7F, 8'hC3);
        reg_write(8'h05, 8'h11);
        reg_read(8'h20, v); check("R2 byte 0x20", v, 8'h5A);
        reg_read(8'h7F, v); check("R2 byte 0x7F", v, 8'hC3);
        reg_read(8'h05, v); check("R2 byte 0x05", v, 8'h11);
        reg_read(8'h0B, v); check("R2 mode untouched", v, 8'h02);
    endtask

    task automatic t_readonly();
        logic [7:0] v;
        do_reset();
        reg_write(8'h0C, 8'hFF);
        check("R5 irq after status write", {7'd0, irq_o}, 8'h00);
        reg_read(8'h0C, v); check("R5 status write ignored", v, 8'h00);
        reg_write(8'h0D, 8'h00);
        reg_read(8'h0D, v); check("R5 valid write ignored", v, 8'h80);
        reg_write(8'h0A, 8'hA6);
        reg_read(8'h0A, v); check("R5 uip bit not writable", v, 8'h26);
    endtask

    task automatic t_flags();
        logic [7:0] v;
        do_reset();
        bus_write(1'b0, 8'h0C);
        pulse_ev(1);
        check("R6 no irq when disabled", {7'd0, irq_o}, 8'h00);
        bus_read(1'b1, v); check("R6 alarm flag", v, 8'h20);
        bus_read(1'b1, v); check("R4 status cleared", v, 8'h00);
        reg_write(8'h0B, 8'h22);
        bus_write(1'b0, 8'h0C);
        pulse_ev(1);
        check("R6 irq raised", {7'd0, irq_o}, 8'h01);
        bus_read(1'b1, v); check("R6 alarm with request", v, 8'hA0);
        check("R4 irq lowered by read", {7'd0, irq_o}, 8'h00);
        pulse_ev(2);
        bus_read(1'b1, v); check("R6 periodic flag only", v, 8'h40);
    endtask

    task automatic t_enable_pending();
        logic [7:0] v;
        do_reset();
        pulse_ev(2);
        check("R8 pending no irq", {7'd0, irq_o}, 8'h00);
        reg_write(8'h0B, 8'h42);
        check("R8 enable on pending raises", {7'd0, irq_o}, 8'h01);
        reg_write(8'h0B, 8'h22);
        check("R8 no overlap lowers", {7'd0, irq_o}, 8'h00);
        reg_read(8'h0C, v); check("R8 request cleared flag kept", v, 8'h40);
    endtask

    task automatic t_concurrent();
        logic [7:0] v;
        do_reset();
        reg_write(8'h0B, 8'h12);
        bus_write(1'b0, 8'h0C);
        @(negedge clk);
        host_rd = 1'b1; host_addr = 1'b1; ev_update = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0; ev_update = 1'b0;
        check("R4 read value before event", v, 8'h00);
        check("R4 event survives read", {7'd0, irq_o}, 8'h01);
        bus_read(1'b1, v); check("R4 flag after concurrent read", v, 8'h90);
    endtask

    task automatic t_uip();
        logic [7:0] v;
        do_reset();
        bus_write(1'b0, 8'h0A);
        give_ticks(TPS - UIT - 1);
        bus_read(1'b1, v); check("R10 before window", v, 8'h26);
        give_ticks(1);
        bus_read(1'b1, v); check("R10 window start", v, 8'hA6);
        give_ticks(UIT - 1);
        bus_read(1'b1, v); check("R10 window end", v, 8'hA6);
        give_ticks(1);
        bus_read(1'b1, v); check("R10 after wrap", v, 8'h26);
    endtask

    task automatic t_set();
        logic [7:0] v;
        do_reset();
        give_ticks(TPS - UIT);
        reg_read(8'h0A, v); check("R10 in window", v, 8'hA6);
        reg_write(8'h0B, 8'h92);
        reg_read(8'h0B, v); check("R7 uie forced low", v, 8'h82);
        reg_read(8'h0A, v); check("R7 uip low in set mode", v, 8'h26);
        check("R11 not running in set mode", {7'd0, clk_run}, 8'h00);
        give_ticks(10);
        reg_write(8'h0B, 8'h02);
        reg_read(8'h0A, v); check("R11 phase frozen", v, 8'hA6);
        give_ticks(UIT);
        reg_read(8'h0A, v); check("R11 phase resumes", v, 8'h26);
        reg_write(8'h0A, 8'h36);
        check("R11 divider code 011 stops", {7'd0, clk_run}, 8'h00);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        do_reset();
        give_ticks(5);
        reg_write(8'h0A, 8'h66);
        give_ticks(40);
        reg_read(8'h0A, v); check("R12 held no uip", v, 8'h66);
        check("R12 held not running", {7'd0, clk_run}, 8'h00);
        reg_write(8'h0A, 8'h26);
        bus_write(1'b0, 8'h0A);
        give_ticks(TPS/2 - UIT - 1);
        bus_read(1'b1, v); check("R12 before first window", v, 8'h26);
        give_ticks(1);
        bus_read(1'b1, v); check("R12 first window half second", v, 8'hA6);
    endtask

    task automatic t_func();
        logic [7:0] v;
        do_reset();
        reg_write(8'h0B, 8'h7E);
        pulse_ev(0);
        check("R6 update irq", {7'd0, irq_o}, 8'h01);
        @(negedge clk); func_rst = 1'b1;
        @(negedge clk); func_rst = 1'b0;
        check("R9 irq lowered", {7'd0, irq_o}, 8'h00);
        reg_read(8'h0B, v); check("R9 enables cleared", v, 8'h16);
        reg_read(8'h0C, v); check("R9 flags cleared", v, 8'h00);
    endtask

    initial begin
        #(5ns * 100000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_index();
        t_store();
        t_readonly();
        t_flags();
        t_enable_pending();
        t_concurrent();
        t_uip();
        t_set();
        t_hold();
        t_func();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule